// File: doc/BRIEF.md
# Two-Port GPIO Register Bank

This block holds the per-port state of a 16-pin general-purpose I/O expander: for each 8-bit port an output latch, a polarity mask and a direction mask, plus a read-only view of the synchronized pin levels. A serial front end (outside this block) turns bus traffic into single-byte register requests. The block takes each request on a valid/ready channel and returns read data on a second valid/ready channel. It also drives the pad controls directly from the stored registers.

Requests carry a register address, a write flag and a data byte. An address is `{kind[1:0], port}`, so the `kind` field sits above the port-select bit. Kind 0 is the pin view, 1 the output latch, 2 the polarity mask and 3 the direction mask. Port p owns pins `[8p+7:8p]`.

Back-pressure works through a single response slot. `req_ready` is high when the slot is empty or is being drained in the same cycle. A held response keeps its data until `rsp_ready` takes it. Writes use no slot and produce no response.

Top module: `gpio_regbank`

## Requirements
- R1: After reset the output latches read 8'hFF, the polarity masks read 8'h00 and the direction masks read 8'hFF. `pin_oe` is all 0, `pin_out` is all 1 and `rsp_valid` is low.
- R2: Address bit 0 selects the port. Bits [2:1] select the kind: 0 pin view, 1 output latch, 2 polarity mask, 3 direction mask. Each of the six writable registers holds its own value independently.
- R3: A write to kind 0 (address 0 or 1) changes no register, no pad control and no later read.
- R4: A kind-0 read returns the synchronized level of every pin of that port, whether the pin is an input or an output.
- R5: In a kind-0 read, a polarity-mask bit of 1 inverts the matching pin bit and a bit of 0 passes it unchanged.
- R6: `pin_oe[i]` is the inverse of direction-mask bit i. A direction bit of 1 turns the driver off, so the pin is an input; a bit of 0 enables it.
- R7: `pin_out[i]` always equals output-latch bit i. A kind-1 read returns the latch contents, not the pin level.
- R8: `pin_in` passes through two flops. A read accepted on the first or second clock edge after a pin change returns the old level; a read accepted on the third returns the new level.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_data` holds steady. An accepted write produces no response.
- R10: Each accepted read gives exactly one response, in request order, with `rsp_valid` high from the edge that accepted it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register address {kind, port} |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 8 | Read byte |
| pin_in | input | 16 | Raw pad levels |
| pin_out | output | 16 | Pad output values |
| pin_oe | output | 16 | Pad driver enables, 1 = driving |

## Verification
The bench builds the block with its defaults: 8-bit ports, two ports and two synchronizer stages. With these values each address holds a single port-select bit, so every one of the eight register addresses is reached. The sync depth of two makes the old-old-new read sequence after a pin change a fixed pattern the bench can predict edge by edge. A single response slot means one withheld `rsp_ready` is enough to reach the full-slot stall.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  typedef enum logic [1:0] {
    KIND_PINS = 2'd0,
    KIND_OUT  = 2'd1,
    KIND_POL  = 2'd2,
    KIND_DIR  = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpx_port.sv
module gpx_port
  import gpx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  reg_kind_e    wr_kind,
  input  logic [W-1:0] wr_data,
  input  reg_kind_e    rd_kind,
  input  logic [W-1:0] pins_sync,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] drv_val,
  output logic [W-1:0] drv_en
);
  logic [W-1:0] out_q, pol_q, dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '1;
      pol_q <= '0;
      dir_q <= '1;
    end else if (wr_en) begin
      case (wr_kind)
        KIND_OUT: out_q <= wr_data;
        KIND_POL: pol_q <= wr_data;
        KIND_DIR: dir_q <= wr_data;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (rd_kind)
      KIND_PINS: rd_data = pins_sync ^ pol_q;
      KIND_OUT:  rd_data = out_q;
      KIND_POL:  rd_data = pol_q;
      default:   rd_data = dir_q;
    endcase
  end

  assign drv_val = out_q;
  assign drv_en  = ~dir_q;
endmodule

// File: rtl/gpx_rsp_slot.sv
module gpx_rsp_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         free
);
  assign free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpx_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int NUM_PORTS   = 2,
  parameter int SYNC_STAGES = 2,
  localparam int PIN_W      = PORT_W * NUM_PORTS,
  localparam int PSEL_W     = $clog2(NUM_PORTS),
  localparam int ADDR_W     = PSEL_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [PORT_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PORT_W-1:0] rsp_data,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe
);
  logic              accept;
  reg_kind_e         kind;
  logic [PSEL_W-1:0] psel;
  logic [PIN_W-1:0]  pins_sync;
  logic [PORT_W-1:0] port_rd [NUM_PORTS];

  assign accept = req_valid && req_ready;
  assign kind   = reg_kind_e'(req_addr[ADDR_W-1 -: 2]);
  assign psel   = req_addr[PSEL_W-1:0];

  gpx_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_in),
    .q    (pins_sync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic sel_wr;
    assign sel_wr = accept && req_write && (psel == PSEL_W'(p));

    gpx_port #(.W(PORT_W)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (sel_wr),
      .wr_kind  (kind),
      .wr_data  (req_wdata),
      .rd_kind  (kind),
      .pins_sync(pins_sync[p*PORT_W +: PORT_W]),
      .rd_data  (port_rd[p]),
      .drv_val  (pin_out[p*PORT_W +: PORT_W]),
      .drv_en   (pin_oe[p*PORT_W +: PORT_W])
    );
  end

  gpx_rsp_slot #(.W(PORT_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept && !req_write),
    .load_data(port_rd[psel]),
    .out_ready(rsp_ready),
    .out_valid(rsp_valid),
    .out_data (rsp_data),
    .free     (req_ready)
  );
endmodule

// File: rtl/gpx_checker.sv
module gpx_checker #(
  parameter int PORT_W      = 8,
  parameter int NUM_PORTS   = 2,
  parameter int SYNC_STAGES = 2,
  localparam int PIN_W      = PORT_W * NUM_PORTS,
  localparam int PSEL_W     = $clog2(NUM_PORTS),
  localparam int ADDR_W     = PSEL_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [PORT_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [PORT_W-1:0] rsp_data,
  input logic [PIN_W-1:0]  pin_out,
  input logic [PIN_W-1:0]  pin_oe
);
  localparam logic [ADDR_W-1:0] A_OUT0 = {2'b01, {PSEL_W{1'b0}}};
  localparam logic [ADDR_W-1:0] A_DIR0 = {2'b11, {PSEL_W{1'b0}}};

  logic wr_acc, rd_acc;
  assign wr_acc = req_valid && req_ready && req_write;
  assign rd_acc = req_valid && req_ready && !req_write;

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && pin_out == '1 && !rsp_valid));

  p_pins_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && req_addr[ADDR_W-1 -: 2] == 2'b00) |=> ($stable(pin_oe) && $stable(pin_out)));

  p_dir_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && req_addr == A_DIR0) |=> (pin_oe[PORT_W-1:0] == ~$past(req_wdata)));

  p_out_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && req_addr == A_OUT0) |=> (pin_out[PORT_W-1:0] == $past(req_wdata)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  p_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_wr_norsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> !rsp_valid);

  p_rd_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);
endmodule

bind gpio_regbank gpx_checker #(
  .PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS), .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/gpio_regbank_test.sv
`timescale 1ns/1ps
module gpio_regbank_test;
  localparam int PW = 8;
  localparam int NP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_data;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out;
  logic [15:0] pin_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] m_out [NP];
  logic [7:0] m_pol [NP];
  logic [7:0] m_dir [NP];

  always #10 clk = ~clk;

  gpio_regbank uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Monitor: pops one expectation per completed response transfer
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check("R9 response with no read pending", 32'd1, 32'd0);
        end else begin
          check(tag_q.pop_front(), {24'd0, rsp_data}, {24'd0, exp_q.pop_front()});
        end
      end
    end
  end

  task automatic send(logic wr, logic [2:0] a, logic [7:0] d,
                      logic setp = 1'b0, logic [15:0] pv = '0);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (setp) pin_in = pv;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    int p = a[0];
    case (a[2:1])
      2'd1: m_out[p] = d;
      2'd2: m_pol[p] = d;
      2'd3: m_dir[p] = d;
      default: ;
    endcase
    send(1'b1, a, d);
  endtask

  function automatic logic [7:0] model_rd(logic [2:0] a, logic [15:0] pins);
    int p = a[0];
    case (a[2:1])
      2'd0: return pins[p*8 +: 8] ^ m_pol[p];
      2'd1: return m_out[p];
      2'd2: return m_pol[p];
      default: return m_dir[p];
    endcase
  endfunction

  task automatic rd(logic [2:0] a, string tag);
    exp_q.push_back(model_rd(a, pin_in));
    tag_q.push_back(tag);
    send(1'b0, a, 8'h00);
  endtask

  task automatic settle_pins(logic [15:0] v);
    @(negedge clk); pin_in = v;
    repeat (3) @(posedge clk);
  endtask

  task automatic check_pads(string tag);
    @(negedge clk); #3;
    check({tag, " pin_oe"}, {16'd0, pin_oe}, {16'd0, ~{m_dir[1], m_dir[0]}});
    check({tag, " pin_out"}, {16'd0, pin_out}, {16'd0, m_out[1], m_out[0]});
  endtask

  task automatic finish_run();
    repeat (4) @(posedge clk);
    check("R10 all reads answered", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      m_out[p] = 8'hFF; m_pol[p] = 8'h00; m_dir[p] = 8'hFF;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rsp_valid after reset", rsp_valid, 0);
    check("R1 pin_oe after reset", pin_oe, 16'h0000);
    check("R1 pin_out after reset", pin_out, 16'hFFFF);
    rst_n = 1'b1;

    // R1: register defaults through reads
    for (int a = 2; a < 8; a++) rd(3'(a), "R1 default readback");

    // R2 / R6 / R7: distinct values in every writable register
    wr(3'd2, 8'hA5); wr(3'd3, 8'h3C);
    wr(3'd4, 8'h0F); wr(3'd5, 8'h81);
    wr(3'd6, 8'hF0); wr(3'd7, 8'h5A);
    check_pads("R6 R7 after writes");
    for (int a = 2; a < 8; a++) rd(3'(a), "R2 independent readback");

    // R7: latch read returns stored value even with pins forced otherwise
    settle_pins(16'h0000);
    rd(3'd2, "R7 out0 read vs pin");
    rd(3'd3, "R7 out1 read vs pin");

    // R4 / R5: pin view on all pins, through polarity masks
    settle_pins(16'h1234);
    rd(3'd0, "R4 R5 in0 mixed directions");
    rd(3'd1, "R4 R5 in1 mixed directions");
    wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    rd(3'd0, "R4 in0 no inversion");
    rd(3'd1, "R4 in1 no inversion");
    wr(3'd4, 8'hFF);
    rd(3'd0, "R5 in0 full inversion");
    wr(3'd6, 8'h00);
    settle_pins(16'hC3E7);
    rd(3'd0, "R4 in0 all outputs");
    check_pads("R6 all port0 outputs");

    // R3: writes to pin-view addresses are discarded
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h55);
    check_pads("R3 pads after pin-view write");
    for (int a = 0; a < 8; a++) rd(3'(a), "R3 readback after pin-view write");

    // R8: synchronizer latency, reads on consecutive edges
    wr(3'd4, 8'h00);
    exp_q.push_back(model_rd(3'd0, pin_in)); tag_q.push_back("R8 first edge old");
    send(1'b0, 3'd0, 8'h00, 1'b1, 16'hC35A);
    exp_q.push_back(8'hE7); tag_q.push_back("R8 second edge old");
    send(1'b0, 3'd0, 8'h00);
    rd(3'd0, "R8 third edge new");

    // R10: response valid right after the accepting edge
    send(1'b0, 3'd1, 8'h00);
    exp_q.push_back(8'h00); tag_q.push_back("unused");
    void'(exp_q.pop_back()); void'(tag_q.pop_back());
    exp_q.push_back(8'hC3); tag_q.push_back("R10 in1 data");

    // R9: back-pressure
    @(posedge clk); #1; rsp_ready = 1'b0;
    rd(3'd7, "R9 first held read");
    fork
      rd(3'd3, "R9 second read after stall");
      begin
        for (int i = 0; i < 3; i++) begin
          @(negedge clk); #3;
          check("R9 req_ready low while full", req_ready, 0);
          check("R9 rsp_valid held", rsp_valid, 1);
          check("R9 rsp_data held", rsp_data, 8'h5A);
        end
        @(posedge clk); #1; rsp_ready = 1'b1;
      end
    join
    wr(3'd2, 8'h66);
    @(negedge clk); #3;
    check("R9 no response for write", rsp_valid, 0);
    check_pads("R7 final pads");

    finish_run();
  end
endmodule